// File: doc/BRIEF.md
# Charge Pump Mode and Switch Sequencer

This block is the digital core of a step-down switched-capacitor converter that has nine power switches. Three battery-voltage comparators feed it a 3-bit word. The word is thermometer-coded, so the number of high bits rises with the battery voltage. The block turns that count into one of four conversion ratios: 1/3, 1/2, 2/3 or 1/1. It then runs the switches through a fixed pattern for that ratio.

In the three fractional ratios, two switch sets alternate at a constant rate. That rate is derived from the system clock. An all-off dead gap of configurable length separates every phase. In the 1/1 ratio a static set of switches ties the input to the output and does not toggle.

Each switch's enable is turned into a gate drive that suits its device type:
- PMOS switches get an active-low drive.
- NMOS switches to ground get an active-high drive.
- Complementary switches get both a true drive and an inverted drive.

A mode change never cuts into a running cycle. The new ratio is loaded only after a phase-2 interval and the dead gap that follows it have both finished.

Top module: `cp_switch_seq`

## Requirements
- R1: While `srst` is high, and on the first cycle after it falls, every switch is off and `mode_o` reads 00. "All off" means `gate_p_o` is all ones and `gate_n_o` is all zeros.
- R2: After reset, no switch turns on until a valid thermometer word has been received. The valid words are 000, 001, 011 and 111, where `cmp_i[0]` is the comparator with the lowest threshold.
- R3: The mode code equals the number of high comparator bits: 11 selects 1/3, 10 selects 1/2, 01 selects 2/3 and 00 selects 1/1. `mode_o` shows the mode that is currently active.
- R4: A non-thermometer word (010, 100, 101 or 110) leaves the requested mode unchanged, and the running pattern continues.
- R5: Switch k maps to bit k-1 of the enable vector. The per-phase switch sets are:
  - 1/3: phase 1 turns on switches {1,4,7} and phase 2 turns on {2,6,8,9}.
  - 1/2: phase 1 turns on {1,5} and phase 2 turns on {2,6}.
  - 2/3: phase 1 turns on {1,3,5,7} and phase 2 turns on {2,4,8}.
- R6: In a fractional mode the cycle runs phase 1 for `PHASE_CLKS` cycles, all off for `DEAD_CLKS` cycles, phase 2 for `PHASE_CLKS` cycles, then all off for `DEAD_CLKS` cycles, and repeats.
- R7: In the 1/1 mode, switches 1, 2, 3 and 9 stay on continuously and switches 4 to 8 stay off.
- R8: A new mode is loaded only at the end of the dead gap that follows phase 2. When the block leaves 1/1, it first holds all switches off for `DEAD_CLKS` cycles. Two different nonzero switch sets are never adjacent, and `mode_o` changes only while all switches are off.
- R9: Gate polarity depends on the device type of each switch:
  - Switches 1 and 3 are PMOS: `gate_p_o` low means on, and `gate_n_o` is held 0.
  - Switches 4, 6 and 8 are NMOS: `gate_n_o` high means on, and `gate_p_o` is held 1.
  - Switches 2, 5, 7 and 9 are complementary: `gate_n_o` equals the enable and `gate_p_o` is its inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 3 | Battery comparator outputs, bit 0 has the lowest threshold |
| gate_p_o | output | 9 | P-side gate drive per switch, active low |
| gate_n_o | output | 9 | N-side gate drive per switch, active high |
| mode_o | output | 2 | Active conversion mode code |

## Verification
The comparator word steps through each valid thermometer count in turn. This shows whether each count reaches its own switch sets and mode code, and whether phase and gap lengths are exact.

Non-thermometer words are applied while a fractional mode is running and again while 1/1 is held. This separates "hold the request" from "decode the nearest valid count".

Transitions into and out of 1/1 test the dead gap on both sides. A mid-bypass reset tests the forced-off path.

// File: rtl/cps_pkg.sv
package cps_pkg;
   localparam int unsigned N_SW   = 9;
   localparam int unsigned N_CMP  = 3;
   localparam int unsigned MODE_W = $clog2(N_CMP + 1);

   typedef enum logic [1:0] {
      MODE_1_1 = 2'd0,
      MODE_2_3 = 2'd1,
      MODE_1_2 = 2'd2,
      MODE_1_3 = 2'd3
   } cp_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_BYP  = 3'd1,
      ST_PH1  = 3'd2,
      ST_GAP1 = 3'd3,
      ST_PH2  = 3'd4,
      ST_GAP2 = 3'd5
   } seq_st_e;

   typedef struct packed {
      logic [N_SW-1:0] ph1;
      logic [N_SW-1:0] ph2;
   } sw_pair_t;

   // switch k sits at bit k-1
   localparam logic [N_SW-1:0] BYPASS_SET = 9'b100000111;

   function automatic sw_pair_t ratio_sets(input cp_mode_e m);
      sw_pair_t s;
      unique case (m)
         MODE_1_3: begin s.ph1 = 9'b001001001; s.ph2 = 9'b110100010; end
         MODE_1_2: begin s.ph1 = 9'b000010001; s.ph2 = 9'b000100010; end
         MODE_2_3: begin s.ph1 = 9'b001010101; s.ph2 = 9'b010001010; end
         default:  begin s.ph1 = '0;           s.ph2 = '0;           end
      endcase
      return s;
   endfunction
endpackage

// File: rtl/cps_cmp_sync.sv
module cps_cmp_sync
   import cps_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             srst,
   input  logic [N_CMP-1:0] cmp_i,
   output cp_mode_e         req_mode_o,
   output logic             seen_o
);
   logic [N_CMP-1:0]  cmp_s;
   logic              fill_s;
   logic [MODE_W-1:0] n_hi;
   logic              thermo_ok;
   cp_mode_e          req_q;
   logic              seen_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign cmp_s  = cmp_i;
         assign fill_s = 1'b1;
      end else begin : g_sync
         logic [N_CMP-1:0]       stg_q [SYNC_STAGES];
         logic [SYNC_STAGES-1:0] fill_q;
         always_ff @(posedge clk) begin
            if (srst) begin
               fill_q <= '0;
               for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= '0;
            end else begin
               stg_q[0]  <= cmp_i;
               fill_q[0] <= 1'b1;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  stg_q[i]  <= stg_q[i-1];
                  fill_q[i] <= fill_q[i-1];
               end
            end
         end
         assign cmp_s  = stg_q[SYNC_STAGES-1];
         assign fill_s = fill_q[SYNC_STAGES-1];
      end
   endgenerate

   always_comb begin
      n_hi      = '0;
      thermo_ok = 1'b1;
      for (int i = 0; i < N_CMP; i++) begin
         n_hi = n_hi + MODE_W'(cmp_s[i]);
      end
      for (int i = 1; i < N_CMP; i++) begin
         if (cmp_s[i] && !cmp_s[i-1]) thermo_ok = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (srst) begin
         req_q  <= MODE_1_1;
         seen_q <= 1'b0;
      end else if (fill_s && thermo_ok) begin
         req_q  <= cp_mode_e'(n_hi);
         seen_q <= 1'b1;
      end
   end

   assign req_mode_o = req_q;
   assign seen_o     = seen_q;
endmodule

// File: rtl/cps_phase_seq.sv
module cps_phase_seq
   import cps_pkg::*;
#(
   parameter int unsigned PHASE_CLKS = 121,
   parameter int unsigned DEAD_CLKS  = 4
) (
   input  logic     clk,
   input  logic     srst,
   input  cp_mode_e req_mode_i,
   input  logic     seen_i,
   output seq_st_e  st_o,
   output cp_mode_e act_mode_o
);
   localparam int unsigned MAX_LD = (PHASE_CLKS > DEAD_CLKS) ? PHASE_CLKS : DEAD_CLKS;
   localparam int unsigned CNT_W  = (MAX_LD > 1) ? $clog2(MAX_LD) : 1;
   localparam logic [CNT_W-1:0] PHASE_LD = CNT_W'(PHASE_CLKS - 1);
   localparam logic [CNT_W-1:0] DEAD_LD  = CNT_W'(DEAD_CLKS - 1);

   seq_st_e          st_q,   st_d;
   logic [CNT_W-1:0] cnt_q,  cnt_d;
   cp_mode_e         mode_q, mode_d;
   logic             cnt_end;

   assign cnt_end = (cnt_q == '0);

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      mode_d = mode_q;
      unique case (st_q)
         ST_IDLE: begin
            if (seen_i) begin
               st_d  = ST_GAP2;
               cnt_d = DEAD_LD;
            end
         end
         ST_BYP: begin
            if (req_mode_i != MODE_1_1) begin
               st_d  = ST_GAP2;
               cnt_d = DEAD_LD;
            end
         end
         ST_PH1: begin
            if (cnt_end) begin
               st_d  = ST_GAP1;
               cnt_d = DEAD_LD;
            end else cnt_d = cnt_q - 1'b1;
         end
         ST_GAP1: begin
            if (cnt_end) begin
               st_d  = ST_PH2;
               cnt_d = PHASE_LD;
            end else cnt_d = cnt_q - 1'b1;
         end
         ST_PH2: begin
            if (cnt_end) begin
               st_d  = ST_GAP2;
               cnt_d = DEAD_LD;
            end else cnt_d = cnt_q - 1'b1;
         end
         ST_GAP2: begin
            if (cnt_end) begin
               mode_d = req_mode_i;
               st_d   = (req_mode_i == MODE_1_1) ? ST_BYP : ST_PH1;
               cnt_d  = PHASE_LD;
            end else cnt_d = cnt_q - 1'b1;
         end
         default: begin
            st_d  = ST_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (srst) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         mode_q <= MODE_1_1;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         mode_q <= mode_d;
      end
   end

   assign st_o       = st_q;
   assign act_mode_o = mode_q;
endmodule

// File: rtl/cps_switch_map.sv
module cps_switch_map
   import cps_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            srst,
   input  seq_st_e         st_i,
   input  cp_mode_e        mode_i,
   output logic [N_SW-1:0] on_o
);
   sw_pair_t        sets;
   logic [N_SW-1:0] on_c;

   always_comb begin
      sets = ratio_sets(mode_i);
      unique case (st_i)
         ST_PH1:  on_c = sets.ph1;
         ST_PH2:  on_c = sets.ph2;
         ST_BYP:  on_c = BYPASS_SET;
         default: on_c = '0;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg
         logic [N_SW-1:0] on_q;
         always_ff @(posedge clk) begin
            if (srst) on_q <= '0;
            else      on_q <= on_c;
         end
         assign on_o = on_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ srst;
         assign on_o = on_c;
      end
   endgenerate
endmodule

// File: rtl/cps_gate_drv.sv
module cps_gate_drv
   import cps_pkg::*;
#(
   parameter logic [N_SW-1:0] PMOS_MASK = 9'b000000101,
   parameter logic [N_SW-1:0] NMOS_MASK = 9'b010101000
) (
   input  logic [N_SW-1:0] on_i,
   output logic [N_SW-1:0] gate_p_o,
   output logic [N_SW-1:0] gate_n_o
);
   generate
      for (genvar i = 0; i < N_SW; i++) begin : g_sw
         if (PMOS_MASK[i]) begin : g_pmos
            assign gate_p_o[i] = ~on_i[i];
            assign gate_n_o[i] = 1'b0;
         end else if (NMOS_MASK[i]) begin : g_nmos
            assign gate_p_o[i] = 1'b1;
            assign gate_n_o[i] = on_i[i];
         end else begin : g_cmos
            assign gate_p_o[i] = ~on_i[i];
            assign gate_n_o[i] = on_i[i];
         end
      end
   endgenerate
endmodule

// File: rtl/cp_switch_seq.sv
module cp_switch_seq
   import cps_pkg::*;
#(
   parameter int unsigned     SYNC_STAGES = 2,
   parameter int unsigned     PHASE_CLKS  = 121,
   parameter int unsigned     DEAD_CLKS   = 4,
   parameter bit              REG_OUT     = 1'b1,
   parameter logic [8:0]      PMOS_MASK   = 9'b000000101,
   parameter logic [8:0]      NMOS_MASK   = 9'b010101000
) (
   input  logic       clk,
   input  logic       srst,
   input  logic [2:0] cmp_i,
   output logic [8:0] gate_p_o,
   output logic [8:0] gate_n_o,
   output logic [1:0] mode_o
);
   generate
      if (PHASE_CLKS < 1) begin : g_bad_phase
         $error("PHASE_CLKS must be at least 1");
      end
      if (DEAD_CLKS < 1) begin : g_bad_dead
         $error("DEAD_CLKS must be at least 1");
      end
      if ((PMOS_MASK & NMOS_MASK) != '0) begin : g_bad_mask
         $error("a switch cannot be both PMOS-only and NMOS-only");
      end
      if (MODE_W != 2) begin : g_bad_cmp
         $error("comparator count must give a two-bit mode");
      end
   endgenerate

   cp_mode_e        req_mode;
   logic            seen;
   seq_st_e         st;
   cp_mode_e        act_mode;
   logic [N_SW-1:0] sw_on;

   cps_cmp_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk        (clk),
      .srst       (srst),
      .cmp_i      (cmp_i),
      .req_mode_o (req_mode),
      .seen_o     (seen)
   );

   cps_phase_seq #(.PHASE_CLKS(PHASE_CLKS), .DEAD_CLKS(DEAD_CLKS)) i_seq (
      .clk        (clk),
      .srst       (srst),
      .req_mode_i (req_mode),
      .seen_i     (seen),
      .st_o       (st),
      .act_mode_o (act_mode)
   );

   cps_switch_map #(.REG_OUT(REG_OUT)) i_map (
      .clk    (clk),
      .srst   (srst),
      .st_i   (st),
      .mode_i (act_mode),
      .on_o   (sw_on)
   );

   cps_gate_drv #(.PMOS_MASK(PMOS_MASK), .NMOS_MASK(NMOS_MASK)) i_drv (
      .on_i     (sw_on),
      .gate_p_o (gate_p_o),
      .gate_n_o (gate_n_o)
   );

   assign mode_o = act_mode;
endmodule

// File: rtl/cps_checker.sv
module cps_checker
   import cps_pkg::*;
#(
   parameter logic [8:0] PMOS_MASK = 9'b000000101,
   parameter logic [8:0] NMOS_MASK = 9'b010101000
) (
   input logic       clk,
   input logic       srst,
   input logic [8:0] gate_p_o,
   input logic [8:0] gate_n_o,
   input logic [1:0] mode_o
);
   logic [8:0] on_v;
   sw_pair_t   sets;

   assign on_v = (~gate_p_o & PMOS_MASK) | (gate_n_o & ~PMOS_MASK);
   assign sets = ratio_sets(cp_mode_e'(mode_o));

   // R9: each gate pair agrees with its device type
   a_r9_gate_polarity: assert property (@(posedge clk) disable iff (srst)
      ((gate_n_o & PMOS_MASK) == '0) && ((~gate_p_o & NMOS_MASK) == '0) &&
      (((gate_p_o ^ gate_n_o) | PMOS_MASK | NMOS_MASK) == 9'h1FF));

   // R8: two different nonzero sets are never back to back
   a_r8_gap_between_sets: assert property (@(posedge clk) disable iff (srst)
      (on_v != '0 && $past(on_v) != '0) |-> (on_v == $past(on_v)));

   // R8: the mode moves only while all switches are off
   a_r8_mode_moves_when_off: assert property (@(posedge clk) disable iff (srst)
      (on_v != '0 && $past(on_v) != '0) |-> $stable(mode_o));

   // R7: the 1/1 mode drives only the through set
   a_r7_bypass_set: assert property (@(posedge clk) disable iff (srst)
      (mode_o == 2'd0 && on_v != '0) |-> (on_v == BYPASS_SET));

   // R5: a fractional mode drives only its own phase sets
   a_r5_ratio_sets: assert property (@(posedge clk) disable iff (srst)
      (mode_o != 2'd0 && on_v != '0) |-> (on_v == sets.ph1 || on_v == sets.ph2));
endmodule

bind cp_switch_seq cps_checker #(.PMOS_MASK(PMOS_MASK), .NMOS_MASK(NMOS_MASK)) i_cps_checker (
   .clk      (clk),
   .srst     (srst),
   .gate_p_o (gate_p_o),
   .gate_n_o (gate_n_o),
   .mode_o   (mode_o)
);

// File: tb/test_cp_switch_seq.sv
module test_cp_switch_seq;
   localparam int PH   = 6;
   localparam int DEAD = 2;
   localparam logic [8:0] PM    = 9'b000000101;
   localparam logic [8:0] NM    = 9'b010101000;
   localparam logic [8:0] S13A  = 9'b001001001;
   localparam logic [8:0] S13B  = 9'b110100010;
   localparam logic [8:0] S12A  = 9'b000010001;
   localparam logic [8:0] S12B  = 9'b000100010;
   localparam logic [8:0] S23A  = 9'b001010101;
   localparam logic [8:0] S23B  = 9'b010001010;
   localparam logic [8:0] SBYP  = 9'b100000111;

   logic       clk = 1'b0;
   logic       srst = 1'b1;
   logic [2:0] cmp = 3'b010;
   logic [8:0] gp, gn;
   logic [1:0] mode;

   always #2 clk = ~clk;

   cp_switch_seq #(.PHASE_CLKS(PH), .DEAD_CLKS(DEAD)) i_cp_switch_seq (
      .clk(clk), .srst(srst), .cmp_i(cmp),
      .gate_p_o(gp), .gate_n_o(gn), .mode_o(mode)
   );

   typedef struct {
      logic [8:0] val;
      int         len;
      string      req;
   } exp_t;

   exp_t       expq[$];
   int         n_chk = 0;
   int         n_bad = 0;
   logic       mon_en = 1'b0;
   logic [8:0] cur = '0;
   int         seg_len = 0;
   bit         done = 1'b0;
   event       seg_ev;

   function automatic logic [8:0] on_of(input logic [8:0] p, input logic [8:0] n);
      return (~p & PM) | (n & ~PM);
   endfunction

   function automatic logic [17:0] gates_of(input logic [8:0] on);
      return {(~on | NM), (on & ~PM)};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [8:0] v, input int l, input string r);
      exp_t e;
      e.val = v; e.len = l; e.req = r;
      expq.push_back(e);
   endtask

   task automatic push_periods(input logic [8:0] a, input logic [8:0] b, input int n, input string r);
      for (int k = 0; k < n; k++) begin
         push(a, PH, r); push('0, DEAD, "R6");
         push(b, PH, r); push('0, DEAD, "R6");
      end
   endtask

   task automatic wait_seg(input logic [8:0] v, input int n);
      int k = 0;
      while (k < n) begin
         @(seg_ev);
         if (cur == v) k++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor: splits the switch vector into segments and scores each one
   always @(negedge clk) begin : mon
      logic [8:0] on_now;
      exp_t       e;
      if (mon_en) begin
         on_now = on_of(gp, gn);
         if (on_now != cur) begin
            if (expq.size() == 0) begin
               check(1'b0, "R6", "unexpected segment", 32'(on_now), 32'(cur));
            end else begin
               e = expq.pop_front();
               check(cur == e.val, e.req, "segment set", 32'(cur), 32'(e.val));
               if (e.len != 0)
                  check(seg_len == e.len, e.req, "segment length", 32'(seg_len), 32'(e.len));
            end
            check({gp, gn} == gates_of(on_now), "R9", "gate polarity",
                  32'({gp, gn}), 32'(gates_of(on_now)));
            cur     = on_now;
            seg_len = 1;
            -> seg_ev;
         end else begin
            seg_len++;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      push('0, 0, "R2");
      repeat (4) @(negedge clk);
      check(gp == 9'h1FF && gn == 9'h000, "R1", "gates in reset", 32'({gp, gn}), 32'({9'h1FF, 9'h000}));
      check(mode == 2'd0, "R1", "mode in reset", 32'(mode), 32'd0);
      srst = 1'b0;
      mon_en = 1'b1;
      for (int k = 0; k < 4; k++) begin
         repeat (5) @(negedge clk);
         check(on_of(gp, gn) == '0, "R2", "off before valid word", 32'(on_of(gp, gn)), 32'd0);
      end

      // 1/3
      cmp = 3'b111;
      push_periods(S13A, S13B, 2, "R5");
      wait_seg(S13A, 1);
      check(mode == 2'd3, "R3", "mode for 111", 32'(mode), 32'd3);
      wait_seg(S13A, 1);

      // to 1/2, committed after the running period ends
      cmp = 3'b011;
      push_periods(S12A, S12B, 2, "R8");
      wait_seg(S12A, 1);
      check(mode == 2'd2, "R3", "mode for 011", 32'(mode), 32'd2);

      // non-thermometer word keeps 1/2 running
      cmp = 3'b101;
      push_periods(S12A, S12B, 1, "R4");
      wait_seg(S12A, 1);
      check(mode == 2'd2, "R4", "mode held on 101", 32'(mode), 32'd2);
      wait_seg(S12A, 1);

      // to 2/3
      cmp = 3'b001;
      push_periods(S23A, S23B, 2, "R5");
      wait_seg(S23A, 1);
      check(mode == 2'd1, "R3", "mode for 001", 32'(mode), 32'd1);
      wait_seg(S23A, 1);

      // to 1/1
      cmp = 3'b000;
      push(SBYP, 0, "R7");
      wait_seg(SBYP, 1);
      check(mode == 2'd0, "R3", "mode for 000", 32'(mode), 32'd0);
      repeat (10) @(negedge clk);
      check({gp, gn} == gates_of(SBYP), "R7", "static through set", 32'({gp, gn}), 32'(gates_of(SBYP)));
      cmp = 3'b110;
      repeat (10) @(negedge clk);
      check({gp, gn} == gates_of(SBYP), "R4", "bypass held on 110", 32'({gp, gn}), 32'(gates_of(SBYP)));

      // out of 1/1: one gap, then 1/3, then back to 1/1
      cmp = 3'b111;
      push('0, DEAD, "R8");
      push_periods(S13A, S13B, 1, "R5");
      push(SBYP, 0, "R7");
      wait_seg(S13A, 1);
      check(mode == 2'd3, "R3", "mode after bypass exit", 32'(mode), 32'd3);
      cmp = 3'b000;
      wait_seg(SBYP, 1);
      repeat (5) @(negedge clk);

      // reset in the middle of 1/1
      srst = 1'b1;
      push('0, 0, "R1");
      repeat (3) @(negedge clk);
      check(gp == 9'h1FF && gn == 9'h000, "R1", "gates after mid-run reset", 32'({gp, gn}), 32'({9'h1FF, 9'h000}));
      check(mode == 2'd0, "R1", "mode after mid-run reset", 32'(mode), 32'd0);
      check(expq.size() == 1, "R6", "segments left unseen", 32'(expq.size()), 32'd1);
      finish_run();
   end
endmodule